// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column addresses of one SDRAM read or write burst. A memory controller writes the mode word to it together with the command that programs the memory. It then pulses a start strobe with the first column address of each read or write. From the next clock onward the block presents one column address per cycle, and it marks the final beat of the burst with a last flag.

Beats are ordered in one of two ways. In sequential order the low address bits count upward and wrap inside the aligned block of burst-length columns. In interleave order the low bits are the start address XORed with the beat number. A full-page setting, accepted only with sequential order, walks the entire 512-column page with wraparound and runs until a stop or a new start arrives. A write-mode bit makes every write a single beat while reads keep the programmed length.

A mode word carrying a reserved code is rejected. The block raises an error flag and keeps its previous settings. The decoded read latency is brought out so the controller can time its data path.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, col_valid, col_last and cfg_err are 0 and cas_lat is 2. The settings are burst length 1, sequential order and burst writes.
- R2: On mode_wr the mode word is decoded as follows. Bits 2:0 are the length code (000=1, 001=2, 010=4, 011=8, 111=full page). Bit 3 is the order (0 sequential, 1 interleave). Bits 6:4 are the latency code (010=2, 011=3), shown on cas_lat from the next cycle. Bit 9 set selects single-beat writes.
- R3: A mode word is rejected if it has a reserved length or latency code, the full-page code together with interleave order, or any set bit other than bits 0 to 6 and 9. On rejection cfg_err becomes 1 and every previous setting is kept. A valid mode word clears cfg_err.
- R4: In the cycle after start, col_valid is 1 and col_out equals start_col.
- R5: In sequential order with length L, beat k gives the start column with its low log2(L) bits replaced by (start + k) mod L.
- R6: In interleave order with length L, beat k gives start_col XOR k.
- R7: In full-page mode, beat k gives (start_col + k) mod 512. col_last never rises, and the burst continues until stop or start.
- R8: col_last is 1 exactly on the final beat of a burst of length L. col_valid falls in the cycle after it unless a new start was given.
- R9: When single-beat writes are selected, a start with start_wr=1 produces one beat. A start with start_wr=0 uses the programmed length.
- R10: stop ends the burst, and col_valid is 0 from the next cycle. A start during a burst restarts from its own column. A start in the same cycle as stop wins.
- R11: A burst uses the settings in force at its start. A mode word loaded during the burst, or in the same cycle as its start, applies only to later bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode word load strobe |
| mode_word | input | 12 | Mode word value |
| start | input | 1 | Read or write command strobe |
| start_col | input | 9 | First column of the burst |
| start_wr | input | 1 | 1 when the command is a write |
| stop | input | 1 | Burst stop strobe |
| col_out | output | 9 | Current column address |
| col_valid | output | 1 | col_out holds a burst beat |
| col_last | output | 1 | Final beat of the burst |
| cfg_err | output | 1 | Last mode word was rejected |
| cas_lat | output | 2 | Decoded read latency in cycles |

## Verification
Some properties are checked by assertions on every cycle. The first beat equals the start column, and col_last only appears while a beat is valid. A burst ends after its last beat or after a stop, and it continues while neither has happened. A mode word with a forbidden bit set raises the error flag without changing the latency, and the latency always reads 2 or 3. The address orderings are shown only by the bench's directed scenarios, which are compared against a behavioural model. Those scenarios also cover full-page wraparound, the single-beat write override, restart and mode changes in the middle of a burst, and the keeping of settings after a rejected word.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  // Decoded and accepted burst settings
  typedef struct packed {
    logic [1:0] len_lg;   // log2 of burst length for fixed lengths
    logic       len_full; // whole-page burst
    logic       ilv;      // interleave order
    logic [1:0] lat;      // read latency in cycles (2 or 3)
    logic       wr_one;   // writes forced to a single beat
  } burst_cfg_t;

  localparam logic [2:0] LEN_C1   = 3'b000;
  localparam logic [2:0] LEN_C2   = 3'b001;
  localparam logic [2:0] LEN_C4   = 3'b010;
  localparam logic [2:0] LEN_C8   = 3'b011;
  localparam logic [2:0] LEN_CPG  = 3'b111;
  localparam logic [2:0] LAT_C2   = 3'b010;
  localparam logic [2:0] LAT_C3   = 3'b011;

  localparam burst_cfg_t CFG_RESET = '{len_lg: 2'd0, len_full: 1'b0, ilv: 1'b0,
                                       lat: 2'd2, wr_one: 1'b0};

endpackage

// File: rtl/colgen_mode_reg.sv
module colgen_mode_reg
  import colgen_pkg::*;
#(
  parameter int MODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MODE_W-1:0] word,
  output burst_cfg_t        cfg,
  output logic              err
);

  // Bits that carry fields; every other bit must be zero
  localparam logic [MODE_W-1:0] USED_BITS = MODE_W'(12'h27F);
  localparam logic [MODE_W-1:0] RSV_BITS  = ~USED_BITS;

  logic [2:0] len_code;
  logic [2:0] lat_code;
  logic       len_ok;
  logic       lat_ok;
  logic       rsv_clear;
  logic       word_ok;
  burst_cfg_t cand;
  burst_cfg_t cfg_d;
  logic       err_d;

  assign len_code  = word[2:0];
  assign lat_code  = word[6:4];
  assign rsv_clear = ~|(word & RSV_BITS);

  always_comb begin
    cand          = CFG_RESET;
    cand.ilv      = word[3];
    cand.wr_one   = word[9];
    len_ok        = 1'b1;
    lat_ok        = 1'b1;
    unique case (len_code)
      LEN_C1:  cand.len_lg = 2'd0;
      LEN_C2:  cand.len_lg = 2'd1;
      LEN_C4:  cand.len_lg = 2'd2;
      LEN_C8:  cand.len_lg = 2'd3;
      LEN_CPG: begin
        cand.len_full = 1'b1;
        len_ok        = ~word[3];
      end
      default: len_ok = 1'b0;
    endcase
    unique case (lat_code)
      LAT_C2:  cand.lat = 2'd2;
      LAT_C3:  cand.lat = 2'd3;
      default: lat_ok = 1'b0;
    endcase
  end

  assign word_ok = len_ok & lat_ok & rsv_clear;

  // Next-state: a rejected word leaves the settings untouched
  always_comb begin
    cfg_d = cfg;
    err_d = err;
    if (load) begin
      err_d = ~word_ok;
      if (word_ok) cfg_d = cand;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= CFG_RESET;
      err <= 1'b0;
    end else if (load) begin
      cfg <= cfg_d;
      err <= err_d;
    end
  end

endmodule

// File: rtl/colgen_tracker.sv
module colgen_tracker
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_wr,
  input  logic [COL_W-1:0] start_col,
  input  logic             stop,
  input  burst_cfg_t       cfg,
  input  logic             final_beat,
  output logic             active,
  output logic [COL_W-1:0] base,
  output logic [COL_W-1:0] beat,
  output logic [1:0]       b_lg,
  output logic             b_full,
  output logic             b_ilv
);

  logic             active_d;
  logic [COL_W-1:0] base_d;
  logic [COL_W-1:0] beat_d;
  logic [1:0]       b_lg_d;
  logic             b_full_d;
  logic             b_ilv_d;
  logic             one_beat;
  logic             upd;

  // A write under the single-beat write mode is length 1, non-full
  assign one_beat = start_wr & cfg.wr_one;

  always_comb begin
    active_d = active;
    base_d   = base;
    beat_d   = beat;
    b_lg_d   = b_lg;
    b_full_d = b_full;
    b_ilv_d  = b_ilv;
    if (start) begin
      active_d = 1'b1;
      base_d   = start_col;
      beat_d   = '0;
      b_lg_d   = one_beat ? 2'd0 : cfg.len_lg;
      b_full_d = one_beat ? 1'b0 : cfg.len_full;
      b_ilv_d  = cfg.ilv;
    end else if (stop) begin
      active_d = 1'b0;
    end else if (active) begin
      if (final_beat) active_d = 1'b0;
      else            beat_d   = beat + 1'b1;
    end
  end

  assign upd = start | stop | active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      base   <= '0;
      beat   <= '0;
      b_lg   <= 2'd0;
      b_full <= 1'b0;
      b_ilv  <= 1'b0;
    end else if (upd) begin
      active <= active_d;
      base   <= base_d;
      beat   <= beat_d;
      b_lg   <= b_lg_d;
      b_full <= b_full_d;
      b_ilv  <= b_ilv_d;
    end
  end

endmodule

// File: rtl/colgen_mapper.sv
module colgen_mapper #(
  parameter int COL_W = 9
) (
  input  logic             active,
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [1:0]       lg,
  input  logic             full,
  input  logic             ilv,
  output logic [COL_W-1:0] col,
  output logic             last
);

  logic [COL_W-1:0] low_mask;
  logic [COL_W-1:0] sum;
  logic [COL_W-1:0] seq_col;
  logic [COL_W-1:0] ilv_col;

  // Wrap mask: bit i is in the counted field when i < log2(length)
  for (genvar g = 0; g < COL_W; g++) begin : g_mask
    assign low_mask[g] = (g < int'(lg));
  end

  assign sum     = base + beat;
  assign seq_col = (base & ~low_mask) | (sum & low_mask);
  assign ilv_col = base ^ (beat & low_mask);

  always_comb begin
    if (full)     col = sum;
    else if (ilv) col = ilv_col;
    else          col = seq_col;
  end

  assign last = active & ~full & ((beat & low_mask) == low_mask);

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int MODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic              start_wr,
  input  logic              stop,
  output logic [COL_W-1:0]  col_out,
  output logic              col_valid,
  output logic              col_last,
  output logic              cfg_err,
  output logic [1:0]        cas_lat
);

  burst_cfg_t       cfg;
  logic             active;
  logic [COL_W-1:0] base;
  logic [COL_W-1:0] beat;
  logic [1:0]       b_lg;
  logic             b_full;
  logic             b_ilv;
  logic             final_beat;

  colgen_mode_reg #(.MODE_W(MODE_W)) u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (mode_wr),
    .word  (mode_word),
    .cfg   (cfg),
    .err   (cfg_err)
  );

  colgen_tracker #(.COL_W(COL_W)) u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_wr   (start_wr),
    .start_col  (start_col),
    .stop       (stop),
    .cfg        (cfg),
    .final_beat (final_beat),
    .active     (active),
    .base       (base),
    .beat       (beat),
    .b_lg       (b_lg),
    .b_full     (b_full),
    .b_ilv      (b_ilv)
  );

  colgen_mapper #(.COL_W(COL_W)) u_map (
    .active (active),
    .base   (base),
    .beat   (beat),
    .lg     (b_lg),
    .full   (b_full),
    .ilv    (b_ilv),
    .col    (col_out),
    .last   (final_beat)
  );

  assign col_valid = active;
  assign col_last  = final_beat;
  assign cas_lat   = cfg.lat;

endmodule

// File: rtl/colgen_chk.sv
module colgen_chk #(
  parameter int COL_W  = 9,
  parameter int MODE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_wr,
  input logic [MODE_W-1:0] mode_word,
  input logic              start,
  input logic [COL_W-1:0]  start_col,
  input logic              stop,
  input logic [COL_W-1:0]  col_out,
  input logic              col_valid,
  input logic              col_last,
  input logic              cfg_err,
  input logic [1:0]        cas_lat
);

  localparam logic [MODE_W-1:0] FORBID = ~MODE_W'(12'h27F);

  assert_first_col_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (col_valid && col_out == $past(start_col)));

  assert_last_in_burst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);

  assert_end_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (col_last && !start) |=> !col_valid);

  assert_stop_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !col_valid);

  assert_keeps_going_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_last && !stop) |=> col_valid);

  assert_forbidden_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && |(mode_word & FORBID)) |=> (cfg_err && $stable(cas_lat)));

  assert_lat_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_lat == 2'd2 || cas_lat == 2'd3));

endmodule

bind sdram_burst_colgen colgen_chk #(.COL_W(COL_W), .MODE_W(MODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_wr   (mode_wr),
  .mode_word (mode_word),
  .start     (start),
  .start_col (start_col),
  .stop      (stop),
  .col_out   (col_out),
  .col_valid (col_valid),
  .col_last  (col_last),
  .cfg_err   (cfg_err),
  .cas_lat   (cas_lat)
);

// File: tb/sdram_burst_colgen_tb.sv
module sdram_burst_colgen_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_wr;
  logic [11:0] mode_word;
  logic        start;
  logic [8:0]  start_col;
  logic        start_wr;
  logic        stop;
  logic [8:0]  col_out;
  logic        col_valid;
  logic        col_last;
  logic        cfg_err;
  logic [1:0]  cas_lat;

  always #5 clk = ~clk;

  sdram_burst_colgen u_dut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_word(mode_word),
    .start(start), .start_col(start_col), .start_wr(start_wr), .stop(stop),
    .col_out(col_out), .col_valid(col_valid), .col_last(col_last),
    .cfg_err(cfg_err), .cas_lat(cas_lat)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    cmp_on = 0;

  // Behavioural reference state
  int m_len = 1, m_full = 0, m_ilv = 0, m_lat = 2, m_one = 0, m_err = 0;
  int m_act = 0, m_base = 0, m_beat = 0, b_len = 1, b_full = 0, b_ilv = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_col();
    if (b_full) return (m_base + m_beat) % 512;
    if (b_ilv)  return m_base ^ m_beat;
    return (m_base / b_len) * b_len + ((m_base % b_len) + m_beat) % b_len;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_len = 1; m_full = 0; m_ilv = 0; m_lat = 2; m_one = 0; m_err = 0; m_act = 0;
    end else begin
      if (start) begin
        m_act = 1; m_base = int'(start_col); m_beat = 0; b_ilv = m_ilv;
        if (start_wr && m_one) begin b_len = 1; b_full = 0; end
        else begin b_len = m_len; b_full = m_full; end
      end else if (stop) m_act = 0;
      else if (m_act) begin
        if (!b_full && m_beat == b_len - 1) m_act = 0;
        else m_beat = (m_beat + 1) % 512;
      end
      if (mode_wr) begin
        int len, full, lat;
        bit good;
        good = ((int'(mode_word) & 'hD80) == 0);
        full = 0; len = 1; lat = 0;
        case (int'(mode_word[2:0]))
          0: len = 1; 1: len = 2; 2: len = 4; 3: len = 8;
          7: begin full = 1; if (mode_word[3]) good = 0; end
          default: good = 0;
        endcase
        case (int'(mode_word[6:4]))
          2: lat = 2; 3: lat = 3;
          default: good = 0;
        endcase
        if (good) begin
          m_len = len; m_full = full; m_ilv = int'(mode_word[3]);
          m_lat = lat; m_one = int'(mode_word[9]); m_err = 0;
        end else m_err = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(col_valid == m_act[0], cur_req, "col_valid", int'(col_valid), m_act);
      if (m_act != 0) begin
        chk(int'(col_out) == exp_col(), cur_req, "col_out", int'(col_out), exp_col());
        chk(col_last == (!b_full && m_beat == b_len - 1), "R8", "col_last",
            int'(col_last), int'(!b_full && m_beat == b_len - 1));
      end
      chk(cfg_err == m_err[0], cur_req, "cfg_err", int'(cfg_err), m_err);
      chk(int'(cas_lat) == m_lat, cur_req, "cas_lat", int'(cas_lat), m_lat);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_mode(logic [11:0] w);
    @(negedge clk); mode_wr = 1; mode_word = w;
    @(negedge clk); mode_wr = 0;
  endtask

  task automatic go(logic [8:0] c, logic wr);
    @(negedge clk); start = 1; start_col = c; start_wr = wr;
    @(negedge clk); start = 0; start_wr = 0;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 0; mode_wr = 0; mode_word = '0; start = 0; start_col = '0;
    start_wr = 0; stop = 0;
    idle(3);
    rst_n = 1;
    @(negedge clk);
    // R1: reset values at the ports
    chk(!col_valid && !col_last, "R1", "valid/last", int'(col_valid), 0);
    chk(!cfg_err, "R1", "cfg_err", int'(cfg_err), 0);
    chk(cas_lat == 2'd2, "R1", "cas_lat", int'(cas_lat), 2);
    cmp_on = 1;
    cur_req = "R1"; go(9'd77, 1'b0); idle(2);            // default length 1
    cur_req = "R2"; load_mode(12'h032); idle(1);          // seq BL4, latency 3
    cur_req = "R5"; go(9'd30, 1'b0); idle(5);             // 30,31,28,29
    load_mode(12'h023); go(9'd13, 1'b0); idle(9);         // seq BL8
    load_mode(12'h021); go(9'd7, 1'b1); idle(3);          // seq BL2
    cur_req = "R6"; load_mode(12'h02B); go(9'h105, 1'b0); idle(9);
    load_mode(12'h039); go(9'h0AA, 1'b0); idle(3);        // ilv BL2 lat3
    cur_req = "R7"; load_mode(12'h027); go(9'd510, 1'b0); idle(8);
    @(negedge clk); stop = 1; @(negedge clk); stop = 0; idle(2);
    cur_req = "R3";
    load_mode(12'h024); idle(1);                          // length code 100
    load_mode(12'h02F); idle(1);                          // full page + interleave
    load_mode(12'h052); idle(1);                          // latency code 101
    load_mode(12'h432); idle(1);                          // forbidden bit 10
    load_mode(12'h0A2); idle(1);                          // forbidden bit 7
    go(9'd100, 1'b0); idle(4);                            // still full page
    @(negedge clk); stop = 1; @(negedge clk); stop = 0; idle(1);
    load_mode(12'h022); idle(1);                          // valid word clears err
    cur_req = "R9"; load_mode(12'h232);
    go(9'd40, 1'b1); idle(3);
    go(9'd40, 1'b0); idle(6);
    load_mode(12'h032); go(9'd41, 1'b1); idle(6);         // burst writes again
    cur_req = "R10"; load_mode(12'h023);
    go(9'd16, 1'b0); idle(2);
    go(9'd50, 1'b0); idle(3);                             // restart mid burst
    @(negedge clk); stop = 1; @(negedge clk); stop = 0; idle(2);
    go(9'd60, 1'b0); idle(1);
    @(negedge clk); stop = 1; start = 1; start_col = 9'd200;
    @(negedge clk); stop = 0; start = 0; idle(10);        // start wins
    cur_req = "R11"; go(9'd33, 1'b0); load_mode(12'h02A); idle(9);
    @(negedge clk); start = 1; start_col = 9'd70; mode_wr = 1; mode_word = 12'h021;
    @(negedge clk); start = 0; mode_wr = 0; idle(5);
    go(9'd70, 1'b0); idle(3);
    cmp_on = 0;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule